// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns a free-running CAN protocol clock into nominal bit timing. A programmable prescaler divides the clock into time quanta. Each bit is built from a fixed one-quantum synchronisation segment, then a programmable phase segment A, then a programmable phase segment B. The block issues a one-clock quantum tick, a one-clock sample strobe on the last quantum of segment A, and a one-clock bit-end strobe on the last quantum of segment B. The bit period in clocks is the divide value times the quanta per bit.

Configuration is guarded by a hold bit. The hold bit comes up set after hardware reset. While it is set, the timing register accepts writes, the prescaler and segment counters stay at zero, and no strobes are produced. Clearing it starts bit timing from a fresh synchronisation segment. While it is clear, writes to the timing register are discarded.

The segment sequencer is a three-state machine: `SYNC` (one quantum), `SEG_A` and `SEG_B`. Its transitions are taken only on a quantum tick: `SYNC -> SEG_A` always; `SEG_A -> SEG_A` while the quantum count is below the segment A code, and `SEG_A -> SEG_B` when it equals the code; `SEG_B -> SEG_B` while below the segment B code, and `SEG_B -> SYNC` when equal. Hold forces `SYNC` with a zero count.

Top module: `can_bit_timer`

## Requirements
- R1: After `rst_n` is released, `hold` is 1, `cfg_q` is 0, and `tq_tick`, `sample_pt` and `bit_end` are 0.
- R2: A `cfg_wr` pulse loads `cfg_din` into `cfg_q` only when `hold` is 1. With `hold` at 0 the write is discarded and `cfg_q` and the strobes are unchanged. Field layout: [5:0] prescaler code, [9:6] segment A code, [12:10] segment B code.
- R3: A `ctrl_wr` pulse loads `ctrl_din` into `hold` at the next clock edge.
- R4: With hold clear, `tq_tick` is a one-clock pulse every D = prescaler code + 1 clocks. Counting the first clock after the release as cycle 0, the first pulse is in cycle D-1.
- R5: Segment A lasts segment A code + 1 quanta (1 to 16). Segment B lasts segment B code + 1 quanta (1 to 8).
- R6: A bit lasts N = 3 + code A + code B quanta, so the bit period is D*N clocks.
- R7: `sample_pt` is a one-clock pulse that coincides with the tick ending quantum index code A + 1 of each bit, which is the last quantum of segment A.
- R8: `bit_end` is a one-clock pulse that coincides with the tick ending quantum N-1 of each bit. The next quantum is the synchronisation segment.
- R9: While `hold` is 1, `tq_tick`, `sample_pt` and `bit_end` stay 0. After the release, timing restarts at the synchronisation segment with the prescaler at zero.
- R10: `sample_pt` and `bit_end` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CAN protocol clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctrl_wr | input | 1 | Write strobe for the hold bit |
| ctrl_din | input | 1 | New hold value |
| cfg_wr | input | 1 | Write strobe for the timing register |
| cfg_din | input | 13 | Timing register write data |
| hold | output | 1 | Current hold (soft reset) state |
| cfg_q | output | 13 | Current timing register contents |
| tq_tick | output | 1 | Quantum-end pulse |
| sample_pt | output | 1 | Sample-point pulse |
| bit_end | output | 1 | Bit-boundary pulse |

## Verification
The bench sweeps every segment A and segment B code at three prescaler values, plus the largest divide. In every cycle of two bit times it compares all three strobes against positions worked out arithmetically. A sequencer that reads a code as the length instead of code + 1 puts the sample point one quantum early. A segment terminal count that is off by one slips `bit_end` by a whole quantum. The codes 0 and 1 in segment B catch both faults. A prescaler whose first tick arrives one clock late drifts every strobe. The single-clock divide, where the tick is high in every cycle, catches that fault. A register write made while hold is clear is issued mid-bit for every configuration. A design that lets it through changes `cfg_q` and the strobe positions that follow.

// File: rtl/can_bit_timer_pkg.sv
package can_bit_timer_pkg;
    localparam int PSC_W  = 6;
    localparam int SEGA_W = 4;
    localparam int SEGB_W = 3;
    localparam int CFG_W  = PSC_W + SEGA_W + SEGB_W;

    typedef enum logic [1:0] {
        SYNC  = 2'd0,
        SEG_A = 2'd1,
        SEG_B = 2'd2
    } seg_state_t;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs #(
    parameter int CFG_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_din,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_din,
    output logic             hold_q,
    output logic [CFG_W-1:0] cfg_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b1;
        end else if (ctrl_wr) begin
            hold_q <= ctrl_din;
        end
    end

    // timing register only accepts data while hold is set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr && hold_q) begin
            cfg_q <= cfg_din;
        end
    end
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int PSC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [PSC_W-1:0] psc_code,
    output logic             tq_tick
);
    logic [PSC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (hold || (pcnt == psc_code)) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    always_comb begin
        tq_tick = !hold && (pcnt == psc_code);
    end
endmodule

// File: rtl/cbt_seg_fsm.sv
module cbt_seg_fsm
    import can_bit_timer_pkg::*;
#(
    parameter int SEGA_W = 4,
    parameter int SEGB_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              tq_tick,
    input  logic [SEGA_W-1:0] sega_code,
    input  logic [SEGB_W-1:0] segb_code,
    output logic              sample_pt,
    output logic              bit_end
);
    localparam int QC_W = (SEGA_W > SEGB_W) ? SEGA_W : SEGB_W;

    seg_state_t state_q, state_d;
    logic [QC_W-1:0] qcnt_q, qcnt_d;
    logic a_last, b_last;

    assign a_last = (qcnt_q == QC_W'(sega_code));
    assign b_last = (qcnt_q == QC_W'(segb_code));

    always_comb begin
        state_d = state_q;
        qcnt_d  = qcnt_q;
        if (hold) begin
            state_d = SYNC;
            qcnt_d  = '0;
        end else if (tq_tick) begin
            unique case (state_q)
                SYNC: begin
                    state_d = SEG_A;
                    qcnt_d  = '0;
                end
                SEG_A: begin
                    if (a_last) begin
                        state_d = SEG_B;
                        qcnt_d  = '0;
                    end else begin
                        qcnt_d = qcnt_q + 1'b1;
                    end
                end
                SEG_B: begin
                    if (b_last) begin
                        state_d = SYNC;
                        qcnt_d  = '0;
                    end else begin
                        qcnt_d = qcnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = SYNC;
                    qcnt_d  = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SYNC;
            qcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            qcnt_q  <= qcnt_d;
        end
    end

    always_comb begin
        sample_pt = 1'b0;
        bit_end   = 1'b0;
        unique case (state_q)
            SYNC:    ;
            SEG_A:   sample_pt = tq_tick && a_last;
            SEG_B:   bit_end   = tq_tick && b_last;
            default: ;
        endcase
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import can_bit_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_din,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_din,
    output logic             hold,
    output logic [CFG_W-1:0] cfg_q,
    output logic             tq_tick,
    output logic             sample_pt,
    output logic             bit_end
);
    localparam int SEGA_LO = PSC_W;
    localparam int SEGB_LO = PSC_W + SEGA_W;

    logic [PSC_W-1:0]  psc_code;
    logic [SEGA_W-1:0] sega_code;
    logic [SEGB_W-1:0] segb_code;

    cbt_cfg_regs #(.CFG_W(CFG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .ctrl_din (ctrl_din),
        .cfg_wr   (cfg_wr),
        .cfg_din  (cfg_din),
        .hold_q   (hold),
        .cfg_q    (cfg_q)
    );

    assign psc_code  = cfg_q[PSC_W-1:0];
    assign sega_code = cfg_q[SEGA_LO +: SEGA_W];
    assign segb_code = cfg_q[SEGB_LO +: SEGB_W];

    cbt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .psc_code (psc_code),
        .tq_tick  (tq_tick)
    );

    cbt_seg_fsm #(.SEGA_W(SEGA_W), .SEGB_W(SEGB_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .tq_tick   (tq_tick),
        .sega_code (sega_code),
        .segb_code (segb_code),
        .sample_pt (sample_pt),
        .bit_end   (bit_end)
    );
endmodule

// File: rtl/can_bit_timer_chk.sv
module can_bit_timer_chk
    import can_bit_timer_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             hold,
    input logic [CFG_W-1:0] cfg_q,
    input logic             tq_tick,
    input logic             sample_pt,
    input logic             bit_end
);
    // R2
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hold |=> $stable(cfg_q));

    // R7
    sample_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> tq_tick);

    // R8
    end_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_end |-> tq_tick);

    // R9
    quiet_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> !(tq_tick || sample_pt || bit_end));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sample_pt, bit_end}) <= 1);
endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .cfg_q     (cfg_q),
    .tq_tick   (tq_tick),
    .sample_pt (sample_pt),
    .bit_end   (bit_end)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
    import can_bit_timer_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 1'b0;
    logic ctrl_din = 1'b0;
    logic cfg_wr = 1'b0;
    logic [CFG_W-1:0] cfg_din = '0;
    logic hold;
    logic [CFG_W-1:0] cfg_q;
    logic tq_tick, sample_pt, bit_end;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_din(ctrl_din),
        .cfg_wr(cfg_wr), .cfg_din(cfg_din), .hold(hold), .cfg_q(cfg_q),
        .tq_tick(tq_tick), .sample_pt(sample_pt), .bit_end(bit_end)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_hold(input logic v);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_din = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_cfg(input logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_din = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // one configuration: load under hold, release, compare two bit times
    task automatic run_cfg(input int pc, input int ca, input int cb);
        int d;
        int nq;
        int tot;
        logic [CFG_W-1:0] word;
        d    = pc + 1;
        nq   = 3 + ca + cb;
        tot  = 2 * d * nq;
        word = {3'(cb), 4'(ca), 6'(pc)};
        set_hold(1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            // R9 quiet while held
            check("R9", int'({tq_tick, sample_pt, bit_end}), 0);
        end
        write_cfg(word);
        // R2 write accepted in hold
        check("R2", int'(cfg_q), int'(word));
        set_hold(1'b0);
        // R3 hold cleared by control write
        check("R3", int'(hold), 0);
        for (int c = 0; c < tot; c++) begin
            int q;
            int qb;
            bit et;
            et = ((c % d) == d - 1);
            q  = c / d;
            qb = q % nq;
            // R4 tick cadence
            check("R4", int'(tq_tick), int'(et));
            // R5 R7 sample at end of segment A
            check("R7", int'(sample_pt), int'(et && (qb == ca + 1)));
            // R6 R8 bit boundary at end of segment B
            check("R8", int'(bit_end), int'(et && (qb == nq - 1)));
            if (c == 1) begin
                cfg_wr = 1'b1; cfg_din = ~word;
            end else begin
                cfg_wr = 1'b0;
            end
            @(negedge clk);
        end
        cfg_wr = 1'b0;
        // R2 write while running discarded
        check("R2", int'(cfg_q), int'(word));
    endtask

    initial begin
        fork
            begin
                #(CLK_PERIOD * 190000);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R1 reset state
                check("R1", int'(hold), 1);
                check("R1", int'(cfg_q), 0);
                check("R1", int'({tq_tick, sample_pt, bit_end}), 0);
                for (int p = 0; p < 3; p++)
                    for (int a = 0; a < 16; a++)
                        for (int b = 0; b < 8; b++)
                            run_cfg(p, a, b);
                run_cfg(63, 2, 1);
                run_cfg(63, 15, 7);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule